// File: doc/BRIEF.md
# Serial channel mode and command register front end

This block is the register front end of one channel of an asynchronous serial controller. A byte-wide host bus reaches it at four channel-relative offsets. The mode registers are kept here. So are the clock-select byte and the command register, which is write-only. A read-only status byte is formed from the flags of the receive and transmit engines. The block drives the decoded character format, the baud and FIFO options, the receiver and transmitter enable states, a break state, and one-cycle reset strobes to the shift engines. It also passes holding-register accesses through to those engines.

The three mode registers share offset 0. An internal pointer selects one of them, moves forward on each write, and can be moved by command codes. In a dual-channel part, the second channel's block is selected by address decode outside this block, eight bytes above the first channel.

Top module: `sio_chan_regs`

## Requirements
- R1: After reset, the mode pointer selects MR1. MR0, MR1, MR2 and the clock-select byte are 0x00. The receiver, the transmitter and the break state are off, and all four error flags are clear.
- R2: A write to offset 0 stores the byte in the register the pointer selects. The pointer then moves MR0 to MR1 and MR1 to MR2, and stays on MR2. A read of offset 0 returns the register the pointer selects and does not move the pointer.
- R3: Command code 1 (bits 7:4 of an offset-2 write) moves the pointer to MR1. Command code 11 moves it to MR0.
- R4: MR1 decodes as follows. `word_len` is MR1[1:0], where 0 to 3 mean 5 to 8 data bits. Parity is off when MR1[4] is 1 (field value 4). Otherwise parity is on, and MR1[2] selects odd (1) or even (0).
- R5: `two_stop` is MR2[3]. This gives one stop bit for a low nibble of 0x7 and two stop bits for 0xF.
- R6: MR0 decodes as follows. `baud_mode` is MR0[2:0] (0 normal, 1 and 5 extended). `deep_fifo` is MR0[3]. `tx_half_trig` is MR0[4].
- R7: A write to offset 1 stores the clock-select byte. `rx_rate` is bits 7:4 and `tx_rate` is bits 3:0.
- R8: In a command byte, bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. These bits combine freely with a command code. When enable and disable are both set, disable wins.
- R9: Command codes 2, 3, 4 and 5 each raise `rx_rst`, `tx_rst`, `err_clr` and `brk_chg_clr` respectively. The strobe is high for exactly the one cycle after the write edge.
- R10: Receiver reset (code 2) clears the receiver enable. Transmitter reset (code 3) clears the transmitter enable and the break state. An enable bit written in the same byte is applied after the reset, so the path ends up enabled.
- R11: Code 6 turns the break state on, and code 7 turns it off.
- R12: The status byte read at offset 1 is {break, framing, parity, overrun, tx_empty, tx_ready, rx_full, rx_ready} from bit 7 down to bit 0. The upper four are sticky flags set by one-cycle event inputs. Code 4 clears them, and the clear wins over an event in the same cycle. The lower four bits follow the ready inputs and are not affected by code 4.
- R13: A write to offset 3 raises `tx_load` combinationally, with `tx_byte` equal to the written byte. A read of offset 3 raises `rx_take` and returns `rx_byte`. Offset 2 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Channel select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Channel-relative offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| rx_ready | input | 1 | Receive data available |
| rx_full | input | 1 | Receive FIFO full |
| tx_ready | input | 1 | Transmit holding has room |
| tx_empty | input | 1 | Transmitter idle and empty |
| ovr_evt | input | 1 | Overrun event pulse |
| par_evt | input | 1 | Parity error event pulse |
| frm_evt | input | 1 | Framing error event pulse |
| brk_evt | input | 1 | Received break event pulse |
| rx_byte | input | 8 | Receive holding data |
| tx_load | output | 1 | Transmit holding write strobe |
| tx_byte | output | 8 | Transmit holding data |
| rx_take | output | 1 | Receive holding read strobe |
| word_len | output | 2 | Data bits code (5 + value) |
| par_en | output | 1 | Parity generated and checked |
| par_odd | output | 1 | Odd parity |
| two_stop | output | 1 | Two stop bits |
| baud_mode | output | 3 | Baud table mode |
| deep_fifo | output | 1 | Deep FIFO enable |
| tx_half_trig | output | 1 | Half-level transmit trigger |
| rx_rate | output | 4 | Receiver rate code |
| tx_rate | output | 4 | Transmitter rate code |
| rx_en | output | 1 | Receiver enabled |
| tx_en | output | 1 | Transmitter enabled |
| break_on | output | 1 | Break being sent |
| rx_rst | output | 1 | Receive path reset strobe |
| tx_rst | output | 1 | Transmit path reset strobe |
| err_clr | output | 1 | Error status reset strobe |
| brk_chg_clr | output | 1 | Break-change reset strobe |

## Verification
The bound checker checks these relations on every cycle:
- how the pointer moves on a write to MR1;
- that disable wins over enable;
- that the transmitter is cleared by a reset written without an enable bit;
- that each strobe is traced to its command write;
- that the error flags are empty whenever `err_clr` is high.

Some behaviour is shown only by the bench scenarios:
- the full pointer walk and readback;
- the field decode of each mode register;
- the same-byte ordering of reset and enable;
- the status composition with live ready inputs;
- the holding-register pass-through.

// File: rtl/sio_chan_regs.sv
module sio_chan_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_ready,
  input  logic       rx_full,
  input  logic       tx_ready,
  input  logic       tx_empty,
  input  logic       ovr_evt,
  input  logic       par_evt,
  input  logic       frm_evt,
  input  logic       brk_evt,
  input  logic [7:0] rx_byte,
  output logic       tx_load,
  output logic [7:0] tx_byte,
  output logic       rx_take,
  output logic [1:0] word_len,
  output logic       par_en,
  output logic       par_odd,
  output logic       two_stop,
  output logic [2:0] baud_mode,
  output logic       deep_fifo,
  output logic       tx_half_trig,
  output logic [3:0] rx_rate,
  output logic [3:0] tx_rate,
  output logic       rx_en,
  output logic       tx_en,
  output logic       break_on,
  output logic       rx_rst,
  output logic       tx_rst,
  output logic       err_clr,
  output logic       brk_chg_clr
);

  localparam logic [1:0] PT_MR0 = 2'd0;
  localparam logic [1:0] PT_MR1 = 2'd1;
  localparam logic [1:0] PT_MR2 = 2'd2;

  localparam logic [3:0] OP_PTR1   = 4'd1;
  localparam logic [3:0] OP_RXRST  = 4'd2;
  localparam logic [3:0] OP_TXRST  = 4'd3;
  localparam logic [3:0] OP_ERRCLR = 4'd4;
  localparam logic [3:0] OP_BRKCLR = 4'd5;
  localparam logic [3:0] OP_BRKON  = 4'd6;
  localparam logic [3:0] OP_BRKOFF = 4'd7;
  localparam logic [3:0] OP_PTR0   = 4'd11;

  logic [7:0] mr0, mr1, mr2, clk_sel;
  logic [1:0] ptr;
  logic [3:0] err_flags;
  logic       rx_en_nx, tx_en_nx, brk_nx;

  wire wr_any  = bus_sel & bus_wr;
  wire wr_mode = wr_any & (bus_addr == 2'd0);
  wire wr_csel = wr_any & (bus_addr == 2'd1);
  wire wr_cmd  = wr_any & (bus_addr == 2'd2);
  wire [3:0] op = bus_wdata[7:4];
  wire op_errclr = wr_cmd & (op == OP_ERRCLR);

  assign tx_load = wr_any & (bus_addr == 2'd3);
  assign tx_byte = bus_wdata;
  assign rx_take = bus_sel & bus_rd & (bus_addr == 2'd3);

  assign word_len     = mr1[1:0];
  assign par_en       = ~mr1[4];
  assign par_odd      = mr1[2];
  assign two_stop     = mr2[3];
  assign baud_mode    = mr0[2:0];
  assign deep_fifo    = mr0[3];
  assign tx_half_trig = mr0[4];
  assign rx_rate      = clk_sel[7:4];
  assign tx_rate      = clk_sel[3:0];

  always_comb begin
    rx_en_nx = rx_en;
    tx_en_nx = tx_en;
    brk_nx   = break_on;
    if (wr_cmd) begin
      if (op == OP_RXRST) rx_en_nx = 1'b0;
      if (op == OP_TXRST) begin
        tx_en_nx = 1'b0;
        brk_nx   = 1'b0;
      end
      if (op == OP_BRKON)  brk_nx = 1'b1;
      if (op == OP_BRKOFF) brk_nx = 1'b0;
      if (bus_wdata[0]) rx_en_nx = 1'b1;
      if (bus_wdata[1]) rx_en_nx = 1'b0;
      if (bus_wdata[2]) tx_en_nx = 1'b1;
      if (bus_wdata[3]) tx_en_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr0 <= '0; mr1 <= '0; mr2 <= '0; clk_sel <= '0;
      ptr <= PT_MR1;
      rx_en <= 1'b0; tx_en <= 1'b0; break_on <= 1'b0;
      err_flags <= '0;
      rx_rst <= 1'b0; tx_rst <= 1'b0; err_clr <= 1'b0; brk_chg_clr <= 1'b0;
    end else begin
      if (wr_mode) begin
        case (ptr)
          PT_MR0:  begin mr0 <= bus_wdata; ptr <= PT_MR1; end
          PT_MR1:  begin mr1 <= bus_wdata; ptr <= PT_MR2; end
          default: mr2 <= bus_wdata;
        endcase
      end
      if (wr_cmd && op == OP_PTR1) ptr <= PT_MR1;
      if (wr_cmd && op == OP_PTR0) ptr <= PT_MR0;
      if (wr_csel) clk_sel <= bus_wdata;
      rx_en    <= rx_en_nx;
      tx_en    <= tx_en_nx;
      break_on <= brk_nx;
      if (op_errclr) err_flags <= '0;
      else           err_flags <= err_flags | {brk_evt, frm_evt, par_evt, ovr_evt};
      rx_rst      <= wr_cmd & (op == OP_RXRST);
      tx_rst      <= wr_cmd & (op == OP_TXRST);
      err_clr     <= op_errclr;
      brk_chg_clr <= wr_cmd & (op == OP_BRKCLR);
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_sel && bus_rd) begin
      case (bus_addr)
        2'd0: bus_rdata = (ptr == PT_MR0) ? mr0 : (ptr == PT_MR1) ? mr1 : mr2;
        2'd1: bus_rdata = {err_flags, tx_empty, tx_ready, rx_full, rx_ready};
        2'd3: bus_rdata = rx_byte;
        default: bus_rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/sio_chan_regs_chk.sv
module sio_chan_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [1:0] ptr,
  input logic [3:0] err_flags,
  input logic       rx_en,
  input logic       tx_en,
  input logic       err_clr
);
  wire cmd_w  = bus_sel && bus_wr && bus_addr == 2'd2;
  wire mode_w = bus_sel && bus_wr && bus_addr == 2'd0;

  p_ptr_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w && ptr == 2'd1) |=> ptr == 2'd2);

  p_disable_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && bus_wdata[1]) |=> !rx_en);

  p_txrst_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && bus_wdata[7:4] == 4'd3 && !bus_wdata[2]) |=> !tx_en);

  p_errclr_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |-> $past(cmd_w && bus_wdata[7:4] == 4'd4));

  p_errclr_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |-> err_flags == 4'd0);
endmodule

bind sio_chan_regs sio_chan_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ptr(ptr),
  .err_flags(err_flags), .rx_en(rx_en), .tx_en(tx_en), .err_clr(err_clr)
);

// File: tb/test_sio_chan_regs.sv
module test_sio_chan_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, rx_byte = 0;
  logic rx_ready = 0, rx_full = 0, tx_ready = 0, tx_empty = 0;
  logic ovr_evt = 0, par_evt = 0, frm_evt = 0, brk_evt = 0;
  logic [7:0] bus_rdata, tx_byte;
  logic tx_load, rx_take, par_en, par_odd, two_stop, deep_fifo, tx_half_trig;
  logic rx_en, tx_en, break_on, rx_rst, tx_rst, err_clr, brk_chg_clr;
  logic [1:0] word_len;
  logic [2:0] baud_mode;
  logic [3:0] rx_rate, tx_rate;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sio_chan_regs i_sio_chan_regs (.*);

  // {addr, wdata, {rx_en,tx_en,break_on}, offset-0 readback}
  localparam logic [20:0] VEC [15] = '{
    {2'd0, 8'h13, 3'b000, 8'h00}, {2'd0, 8'h0F, 3'b000, 8'h0F},
    {2'd2, 8'h10, 3'b000, 8'h13}, {2'd2, 8'hB0, 3'b000, 8'h00},
    {2'd0, 8'h1D, 3'b000, 8'h13}, {2'd2, 8'h05, 3'b110, 8'h13},
    {2'd2, 8'h60, 3'b111, 8'h13}, {2'd2, 8'h70, 3'b110, 8'h13},
    {2'd2, 8'h02, 3'b010, 8'h13}, {2'd2, 8'h03, 3'b010, 8'h13},
    {2'd2, 8'h60, 3'b011, 8'h13}, {2'd2, 8'h30, 3'b000, 8'h13},
    {2'd2, 8'h34, 3'b010, 8'h13}, {2'd2, 8'h21, 3'b110, 8'h13},
    {2'd2, 8'h20, 3'b010, 8'h13}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0; bus_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 en/brk", {rx_en, tx_en, break_on}, 3'b000);
    rd(2'd0, r); chk("R1 MR1 readback", r, 8'h00);
    rd(2'd1, r); chk("R1 status", r, 8'h00);
    chk("R1 rates", {rx_rate, tx_rate}, 8'h00);

    // R2 R3 R8 R10 R11 table walk
    foreach (VEC[i]) begin
      wr(VEC[i][20:19], VEC[i][18:11]);
      chk("R8/R10/R11 state", {rx_en, tx_en, break_on}, VEC[i][10:8]);
      rd(2'd0, r);
      chk("R2/R3 readback", r, VEC[i][7:0]);
    end

    // R4 R5 R6 decode
    chk("R4 word_len", word_len, 2'd3);
    chk("R4 parity off", par_en, 1'b0);
    chk("R5 two stop", two_stop, 1'b1);
    chk("R6 mr0 fields", {baud_mode, deep_fifo, tx_half_trig}, {3'd5, 1'b1, 1'b1});
    wr(2'd2, 8'h10);
    wr(2'd0, 8'h06);
    wr(2'd0, 8'h07);
    chk("R4 word_len 7", word_len, 2'd2);
    chk("R4 odd parity", {par_en, par_odd}, 2'b11);
    chk("R5 one stop", two_stop, 1'b0);
    wr(2'd0, 8'h0F);
    chk("R2 stays on MR2", two_stop, 1'b1);
    chk("R4 MR1 untouched", word_len, 2'd2);

    // R7 clock select
    wr(2'd1, 8'hB7);
    chk("R7 rates", {rx_rate, tx_rate}, 8'hB7);

    // R9 strobes
    wr(2'd2, 8'h50);
    chk("R9 brk_chg_clr", {rx_rst, tx_rst, err_clr, brk_chg_clr}, 4'b0001);
    @(posedge clk); #1;
    chk("R9 one cycle", {rx_rst, tx_rst, err_clr, brk_chg_clr}, 4'b0000);
    wr(2'd2, 8'h20);
    chk("R9 rx_rst", {rx_rst, tx_rst, err_clr, brk_chg_clr}, 4'b1000);
    wr(2'd2, 8'h30);
    chk("R9 tx_rst", {rx_rst, tx_rst, err_clr, brk_chg_clr}, 4'b0100);

    // R12 status
    @(negedge clk);
    rx_ready = 1; tx_empty = 1; ovr_evt = 1; brk_evt = 1;
    @(negedge clk);
    ovr_evt = 0; brk_evt = 0;
    rd(2'd1, r); chk("R12 sticky status", r, 8'h99);
    rd(2'd1, r); chk("R12 still set", r, 8'h99);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'h40; par_evt = 1;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; par_evt = 0;
    chk("R9 err_clr", err_clr, 1'b1);
    rd(2'd1, r); chk("R12 clear wins, ready kept", r, 8'h09);

    // R13 holding pass-through
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 2'd3; bus_wdata = 8'hA5;
    #1 chk("R13 tx_load", {tx_load, tx_byte}, {1'b1, 8'hA5});
    bus_sel = 0; bus_wr = 0;
    rx_byte = 8'h3C;
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = 2'd3;
    #1 chk("R13 rx read", {rx_take, bus_rdata}, {1'b1, 8'h3C});
    bus_sel = 0; bus_rd = 0;
    rd(2'd2, r); chk("R13 cmd reads zero", r, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule